// File: doc/BRIEF.md
# Free-Running Real-Time Counter with Alarm and Wakeup Compare

The block is a memory-mapped real-time counter. A counter, 32 bits wide by default, advances on ticks from one of four clock sources. Each source's ticks arrive as one-cycle enable pulses in the bus clock domain. Two prescaler stages, one dividing by 32 and one by 512, can be switched into the tick path singly or together. Software cannot write the counter. To restart it from zero, software clears the enable bit and then sets it again. The clock source and the prescalers can only be reconfigured while the counter is stopped.

Two compare channels watch the counter, and each raises a sticky flag. The alarm channel uses one compare register. Every accepted write to that register opens a short synchronisation window. While the window is open, the status register shows a busy bit and any further alarm writes are dropped. The wakeup channel uses a second compare register and has its own enable bit. One interrupt output collects both flags through their interrupt-enable bits.

Registers are accessed over a simple single-cycle bus with byte addresses:

| Offset | Register |
|--------|----------|
| 0x04 | control |
| 0x08 | status |
| 0x0C | counter (read-only) |
| 0x10 | wakeup compare |
| 0x14 | alarm compare |

Read data is combinational and is valid in the cycle in which `busRead` is high. A write takes effect at the clock edge at which `busWrite` is high.

Top module: `rtcAlarmTimer`

## Requirements
- R1: After reset the control, status, counter, wakeup-compare and alarm-compare registers all read 0, and `irqOut` is low.
- R2: While control bit 31 (run) is 1, the counter increases by one on each tick that leaves the prescaler chain. Only the source selected by control bits 13:12 produces ticks, and pulses on any other source have no effect.
- R3: Whenever the run bit is 0 the counter is held at 0. After the run bit is set again, counting starts from 0.
- R4: The counter wraps from its maximum value to 0 and keeps counting.
- R5: Control bit 10 divides the selected source by 32. Control bit 11 divides it by 512. With both bits set the division is 16384, and with neither set every source tick counts.
- R6: A control write made while the run bit is already 1 leaves bits 13:10 unchanged. Bits 31, 30, 15 and 14 are always updated.
- R7: A write of 1 to the source-select field is ignored, and the previously selected source stays in use.
- R8: Status bit 29 sets on the tick that brings the counter to the alarm compare value. It never sets while that value is 0.
- R9: Status bit 13 sets on the tick that brings the counter to a nonzero wakeup compare value, but only while control bit 15 is 1.
- R10: Status bits 29 and 13 stay set until software writes 1 to them at offset 0x08. Writing 0 leaves them unchanged.
- R11: `irqOut` is high exactly when status bit 29 is set together with control bit 30, or status bit 13 is set together with control bit 14.
- R12: After an accepted write to the alarm compare register, status bit 18 reads 1 until two ticks of the selected source have arrived. Alarm compare writes made while bit 18 is set are dropped.
- R13: Reads of unmapped offsets return 0. Writes to unmapped offsets, and writes to the counter at 0x0C, change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous system reset |
| busWrite | input | 1 | Write strobe, one cycle per access |
| busRead | input | 1 | Read strobe, enables the read data |
| busAddr | input | ADDR_W (8) | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, 0 when not reading |
| srcTick | input | 4 | One-cycle tick pulses, one per clock source |
| irqOut | output | 1 | Combined alarm and wakeup interrupt |

## Verification
The assertions assume that every tick input is a synchronous pulse. They also assume that the bus performs at most one write per cycle, and that the address and data of a write are stable at the edge where it is sampled. The bench drives all inputs from tasks on the falling clock edge. It keeps every access to a single cycle and raises tick pulses on only one source at a time. The sticky-flag checks assume that the flags can only be cleared by a status write with the matching bit set. The bench therefore clears flags only through such writes, and only after it has read them.

// File: rtl/rtcPkg.sv
package rtcPkg;
  localparam int SRC_COUNT = 4;
  localparam int SEL_W     = $clog2(SRC_COUNT);

  localparam int OFF_CTL   = 'h04;
  localparam int OFF_STAT  = 'h08;
  localparam int OFF_CNT   = 'h0C;
  localparam int OFF_WAKE  = 'h10;
  localparam int OFF_ALARM = 'h14;

  // control field positions
  localparam int B_RUN      = 31;
  localparam int B_ALARM_IE = 30;
  localparam int B_WAKE_EN  = 15;
  localparam int B_WAKE_IE  = 14;
  localparam int B_SEL_LO   = 12;
  localparam int B_DIV512   = 11;
  localparam int B_DIV32    = 10;

  // status field positions
  localparam int B_ALARM_F  = 29;
  localparam int B_BUSY     = 18;
  localparam int B_WAKE_F   = 13;

  typedef struct packed {
    logic             cntEn;
    logic [SEL_W-1:0] clkSel;
    logic             div32En;
    logic             div512En;
    logic             wakeCmpEn;
    logic             alarmWr;
    logic             wakeWr;
    logic [31:0]      wrData;
  } rtcStrobeT;
endpackage

// File: rtl/rtcDivStage.sv
module rtcDivStage #(
  parameter int W = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic stageOn,
  input  logic tickIn,
  output logic tickOut
);
  logic [W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rstN || !run || !stageOn) phase <= '0;
    else if (tickIn)               phase <= phase + 1'b1;
  end

  assign tickOut = stageOn ? (tickIn && (phase == {W{1'b1}})) : tickIn;
endmodule

// File: rtl/rtcCountPath.sv
module rtcCountPath
  import rtcPkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int DIV_LO_W = 5,
  parameter int DIV_HI_W = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rtcStrobeT            strobe,
  input  logic [SRC_COUNT-1:0] srcTick,
  output logic [CNT_W-1:0]     cntVal,
  output logic [31:0]          alarmVal,
  output logic [31:0]          wakeVal,
  output logic                 rawTick,
  output logic                 alarmHit,
  output logic                 wakeHit
);
  localparam int STAGES = 2;

  logic [STAGES:0]   stageTick;
  logic              cntTick;
  logic [CNT_W-1:0]  nextCnt;
  logic [31:0]       nextWide;

  assign rawTick      = srcTick[strobe.clkSel];
  assign stageTick[0] = rawTick;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int SW = (s == 0) ? DIV_HI_W : DIV_LO_W;
    logic stageOn;
    assign stageOn = (s == 0) ? strobe.div512En : strobe.div32En;
    rtcDivStage #(.W(SW)) u_stage (
      .clk    (clk),
      .rstN   (rstN),
      .run    (strobe.cntEn),
      .stageOn(stageOn),
      .tickIn (stageTick[s]),
      .tickOut(stageTick[s+1])
    );
  end

  assign cntTick  = strobe.cntEn && stageTick[STAGES];
  assign nextCnt  = cntVal + 1'b1;
  assign nextWide = 32'(nextCnt);

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.cntEn) cntVal <= '0;
    else if (cntTick)           cntVal <= nextCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmVal <= '0;
      wakeVal  <= '0;
    end else begin
      if (strobe.alarmWr) alarmVal <= strobe.wrData;
      if (strobe.wakeWr)  wakeVal  <= strobe.wrData;
    end
  end

  assign alarmHit = cntTick && (alarmVal != '0) && (nextWide == alarmVal);
  assign wakeHit  = cntTick && strobe.wakeCmpEn && (wakeVal != '0) &&
                    (nextWide == wakeVal);
endmodule

// File: rtl/rtcRegCtl.sv
module rtcRegCtl
  import rtcPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 32,
  parameter int SYNC_TICKS = 2,
  parameter int RSVD_SRC   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [31:0]       alarmVal,
  input  logic [31:0]       wakeVal,
  input  logic              rawTick,
  input  logic              alarmHit,
  input  logic              wakeHit,
  output rtcStrobeT         strobe,
  output logic [31:0]       busRdata,
  output logic              irqOut,
  output logic              alarmFlag,
  output logic              wakeFlag,
  output logic              syncBusy
);
  localparam int BUSY_W = $clog2(SYNC_TICKS + 1);

  logic             runReg, alarmIe, wakeEn, wakeIe, div32Reg, div512Reg;
  logic [SEL_W-1:0] selReg, selReq;
  logic [BUSY_W-1:0] busyCnt;
  logic wrCtl, wrStat, wrWake, wrAlarm, alarmTake;

  assign wrCtl   = busWrite && (busAddr == ADDR_W'(OFF_CTL));
  assign wrStat  = busWrite && (busAddr == ADDR_W'(OFF_STAT));
  assign wrWake  = busWrite && (busAddr == ADDR_W'(OFF_WAKE));
  assign wrAlarm = busWrite && (busAddr == ADDR_W'(OFF_ALARM));
  assign syncBusy  = (busyCnt != '0);
  assign alarmTake = wrAlarm && !syncBusy;
  assign selReq    = busWdata[B_SEL_LO +: SEL_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runReg    <= 1'b0;
      alarmIe   <= 1'b0;
      wakeEn    <= 1'b0;
      wakeIe    <= 1'b0;
      selReg    <= '0;
      div32Reg  <= 1'b0;
      div512Reg <= 1'b0;
    end else if (wrCtl) begin
      runReg  <= busWdata[B_RUN];
      alarmIe <= busWdata[B_ALARM_IE];
      wakeEn  <= busWdata[B_WAKE_EN];
      wakeIe  <= busWdata[B_WAKE_IE];
      if (!runReg) begin
        div32Reg  <= busWdata[B_DIV32];
        div512Reg <= busWdata[B_DIV512];
        if (selReq != SEL_W'(RSVD_SRC)) selReg <= selReq;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     busyCnt <= '0;
    else if (alarmTake)            busyCnt <= BUSY_W'(SYNC_TICKS);
    else if (syncBusy && rawTick)  busyCnt <= busyCnt - 1'b1;
  end

  // a compare hit in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmFlag <= 1'b0;
      wakeFlag  <= 1'b0;
    end else begin
      if (alarmHit)                           alarmFlag <= 1'b1;
      else if (wrStat && busWdata[B_ALARM_F]) alarmFlag <= 1'b0;
      if (wakeHit)                            wakeFlag  <= 1'b1;
      else if (wrStat && busWdata[B_WAKE_F])  wakeFlag  <= 1'b0;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.cntEn     = runReg;
    strobe.clkSel    = selReg;
    strobe.div32En   = div32Reg;
    strobe.div512En  = div512Reg;
    strobe.wakeCmpEn = wakeEn;
    strobe.alarmWr   = alarmTake;
    strobe.wakeWr    = wrWake;
    strobe.wrData    = busWdata;
  end

  always_comb begin
    busRdata = '0;
    if (busRead) begin
      if (busAddr == ADDR_W'(OFF_CTL)) begin
        busRdata[B_RUN]               = runReg;
        busRdata[B_ALARM_IE]          = alarmIe;
        busRdata[B_WAKE_EN]           = wakeEn;
        busRdata[B_WAKE_IE]           = wakeIe;
        busRdata[B_SEL_LO +: SEL_W]   = selReg;
        busRdata[B_DIV512]            = div512Reg;
        busRdata[B_DIV32]             = div32Reg;
      end else if (busAddr == ADDR_W'(OFF_STAT)) begin
        busRdata[B_ALARM_F] = alarmFlag;
        busRdata[B_BUSY]    = syncBusy;
        busRdata[B_WAKE_F]  = wakeFlag;
      end else if (busAddr == ADDR_W'(OFF_CNT)) begin
        busRdata = 32'(cntVal);
      end else if (busAddr == ADDR_W'(OFF_WAKE)) begin
        busRdata = wakeVal;
      end else if (busAddr == ADDR_W'(OFF_ALARM)) begin
        busRdata = alarmVal;
      end
    end
  end

  assign irqOut = (alarmFlag && alarmIe) || (wakeFlag && wakeIe);
endmodule

// File: rtl/rtcAlarmTimer.sv
module rtcAlarmTimer
  import rtcPkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 32,
  parameter int DIV_LO_W   = 5,
  parameter int DIV_HI_W   = 9,
  parameter int SYNC_TICKS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWrite,
  input  logic                 busRead,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [SRC_COUNT-1:0] srcTick,
  output logic                 irqOut
);
  rtcStrobeT        strobe;
  logic [CNT_W-1:0] cntVal;
  logic [31:0]      alarmVal, wakeVal;
  logic             rawTick, alarmHit, wakeHit;
  logic             alarmFlag, wakeFlag, syncBusy;
  logic             cntEnW, div32W, div512W;
  logic [SEL_W-1:0] clkSelW;

  assign cntEnW  = strobe.cntEn;
  assign clkSelW = strobe.clkSel;
  assign div32W  = strobe.div32En;
  assign div512W = strobe.div512En;

  rtcRegCtl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .RSVD_SRC(1)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .cntVal(cntVal),
    .alarmVal(alarmVal), .wakeVal(wakeVal), .rawTick(rawTick),
    .alarmHit(alarmHit), .wakeHit(wakeHit), .strobe(strobe),
    .busRdata(busRdata), .irqOut(irqOut), .alarmFlag(alarmFlag),
    .wakeFlag(wakeFlag), .syncBusy(syncBusy)
  );

  rtcCountPath #(
    .CNT_W(CNT_W), .DIV_LO_W(DIV_LO_W), .DIV_HI_W(DIV_HI_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcTick(srcTick),
    .cntVal(cntVal), .alarmVal(alarmVal), .wakeVal(wakeVal),
    .rawTick(rawTick), .alarmHit(alarmHit), .wakeHit(wakeHit)
  );
endmodule

// File: rtl/rtcAlarmTimerChk.sv
module rtcAlarmTimerChk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              cntEn,
  input logic [1:0]        clkSel,
  input logic              div32En,
  input logic              div512En,
  input logic [CNT_W-1:0]  cntVal,
  input logic [31:0]       alarmVal,
  input logic              alarmFlag,
  input logic              wakeFlag,
  input logic              syncBusy,
  input logic              rawTick,
  input logic              irqOut
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && $past(cntEn)) |->
      (cntVal == $past(cntVal) || cntVal == CNT_W'($past(cntVal) + 1'b1)));

  p_clear_when_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> (cntVal == '0));

  p_cfg_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && $past(cntEn)) |->
      ($stable(clkSel) && $stable(div32En) && $stable(div512En)));

  p_sel_reserved_r7: assert property (@(posedge clk) disable iff (!rstN)
    clkSel != 2'd1);

  p_alarm_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !(busWrite && busAddr == ADDR_W'('h08) && busWdata[29]))
      |=> alarmFlag);

  p_wake_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wakeFlag && !(busWrite && busAddr == ADDR_W'('h08) && busWdata[13]))
      |=> wakeFlag);

  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (alarmFlag || wakeFlag));

  p_busy_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (syncBusy && !rawTick) |=> syncBusy);

  p_alarm_frozen_r12: assert property (@(posedge clk) disable iff (!rstN)
    syncBusy |=> $stable(alarmVal));
endmodule

bind rtcAlarmTimer rtcAlarmTimerChk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .cntEn(cntEnW), .clkSel(clkSelW), .div32En(div32W),
  .div512En(div512W), .cntVal(cntVal), .alarmVal(alarmVal),
  .alarmFlag(alarmFlag), .wakeFlag(wakeFlag), .syncBusy(syncBusy),
  .rawTick(rawTick), .irqOut(irqOut)
);

// File: tb/test_rtcAlarmTimer.sv
`timescale 1ns/1ps
module test_rtcAlarmTimer;
  localparam logic [7:0] A_CTL = 8'h04, A_STAT = 8'h08, A_CNT = 8'h0C,
                         A_WAKE = 8'h10, A_ALARM = 8'h14;
  localparam logic [31:0] S_ALARM = 32'h2000_0000, S_BUSY = 32'h0004_0000,
                          S_WAKE = 32'h0000_2000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrite = 1'b0, busRead = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdWide, rdNarrow;
  logic [3:0]  srcTick = '0;
  logic irqWide, irqNarrow;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rtcAlarmTimer i_rtcAlarmTimer (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdWide),
    .srcTick(srcTick), .irqOut(irqWide));

  rtcAlarmTimer #(.CNT_W(8)) i_rtcAlarmTimerNarrow (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdNarrow),
    .srcTick(srcTick), .irqOut(irqNarrow));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] w, output logic [31:0] n);
    @(negedge clk);
    busRead = 1'b1; busAddr = a;
    #1;
    w = rdWide; n = rdNarrow;
    busRead = 1'b0; busAddr = '0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] w, n;
    rd(a, w, n);
    chk(req, w, exp);
  endtask

  task automatic ticks(input int src, input int n);
    @(negedge clk);
    srcTick = 4'(1 << src);
    repeat (n) @(negedge clk);
    srcTick = '0;
  endtask

  task automatic tReset;
    rdChk("R1 control", A_CTL, 0);
    rdChk("R1 status", A_STAT, 0);
    rdChk("R1 counter", A_CNT, 0);
    rdChk("R1 wake cmp", A_WAKE, 0);
    rdChk("R1 alarm cmp", A_ALARM, 0);
    chk("R1 irq", 32'(irqWide), 0);
  endtask

  task automatic tCount;
    wr(A_CTL, 32'h8000_0000);
    ticks(0, 5);
    rdChk("R2 five ticks", A_CNT, 5);
    ticks(2, 3);
    rdChk("R2 other source ignored", A_CNT, 5);
  endtask

  task automatic tRestart;
    wr(A_CTL, 32'h0);
    rdChk("R3 cleared when stopped", A_CNT, 0);
    ticks(0, 2);
    rdChk("R3 no count when stopped", A_CNT, 0);
    wr(A_CTL, 32'h8000_0000);
    ticks(0, 2);
    rdChk("R3 counts from zero", A_CNT, 2);
  endtask

  task automatic tConfig;
    wr(A_CTL, 32'h8000_2000);
    rdChk("R6 select locked while running", A_CTL, 32'h8000_0000);
    wr(A_CTL, 32'h0);
    wr(A_CTL, 32'h0000_2000);
    rdChk("R6 select taken while stopped", A_CTL, 32'h0000_2000);
    wr(A_CTL, 32'h0000_1000);
    rdChk("R7 reserved select ignored", A_CTL, 32'h0000_0000 | 32'h2000);
    wr(A_CTL, 32'h8000_2000);
    ticks(0, 3);
    rdChk("R2 old source idle", A_CNT, 0);
    ticks(2, 4);
    rdChk("R2 new source counts", A_CNT, 4);
  endtask

  task automatic tPrescale;
    wr(A_CTL, 32'h0);
    wr(A_CTL, 32'h8000_2400);
    ticks(2, 31);
    rdChk("R5 div32 before", A_CNT, 0);
    ticks(2, 1);
    rdChk("R5 div32 at 32", A_CNT, 1);
    wr(A_CTL, 32'h0);
    wr(A_CTL, 32'h8000_2C00);
    rdChk("R5 both dividers set", A_CTL, 32'h8000_2C00);
    ticks(2, 16383);
    rdChk("R5 div16384 before", A_CNT, 0);
    ticks(2, 1);
    rdChk("R5 div16384 at 16384", A_CNT, 1);
    wr(A_CTL, 32'h0);
    wr(A_CTL, 32'h8000_2000);
  endtask

  task automatic tBusy;
    wr(A_ALARM, 32'd6);
    rdChk("R12 busy after write", A_STAT, S_BUSY);
    wr(A_ALARM, 32'd9);
    rdChk("R12 write dropped", A_ALARM, 32'd6);
    ticks(2, 1);
    rdChk("R12 busy after one tick", A_STAT, S_BUSY);
    ticks(2, 1);
    rdChk("R12 busy clear after two", A_STAT, 0);
  endtask

  task automatic tAlarm;
    ticks(2, 3);
    rdChk("R8 no flag before match", A_STAT, 0);
    ticks(2, 1);
    rdChk("R8 counter at match", A_CNT, 6);
    rdChk("R8 flag at match", A_STAT, S_ALARM);
    chk("R11 masked irq", 32'(irqWide), 0);
    wr(A_CTL, 32'hC000_2000);
    chk("R11 alarm irq", 32'(irqWide), 1);
    wr(A_STAT, 32'h0);
    rdChk("R10 zero write keeps flag", A_STAT, S_ALARM);
    wr(A_STAT, S_ALARM);
    rdChk("R10 flag cleared", A_STAT, 0);
    chk("R11 irq drops", 32'(irqWide), 0);
  endtask

  task automatic tWake;
    wr(A_WAKE, 32'd4);
    wr(A_CTL, 32'h4000_2000);
    wr(A_CTL, 32'h8000_2000);
    ticks(2, 4);
    rdChk("R9 no flag while disabled", A_STAT, 0);
    wr(A_CTL, 32'h0000_E000);
    wr(A_CTL, 32'h8000_E000);
    ticks(2, 3);
    rdChk("R9 no flag before match", A_STAT, 0);
    ticks(2, 1);
    rdChk("R9 wake flag", A_STAT, S_WAKE);
    chk("R11 wake irq", 32'(irqWide), 1);
    wr(A_STAT, S_WAKE);
    rdChk("R10 wake cleared", A_STAT, 0);
    chk("R11 wake irq drops", 32'(irqWide), 0);
  endtask

  task automatic tWrap;
    logic [31:0] w, n;
    wr(A_ALARM, 32'd0);
    ticks(2, 2);
    wr(A_CTL, 32'h0000_2000);
    wr(A_CTL, 32'h8000_2000);
    ticks(2, 256);
    rd(A_CNT, w, n);
    chk("R4 narrow wraps to zero", n, 0);
    chk("R4 wide keeps counting", w, 256);
    rd(A_STAT, w, n);
    chk("R8 zero alarm never fires", n, 0);
    chk("R8 zero alarm wide", w, 0);
    ticks(2, 1);
    rd(A_CNT, w, n);
    chk("R4 narrow after wrap", n, 1);
    chk("R4 wide after 257", w, 257);
  endtask

  task automatic tUnmapped;
    wr(A_CNT, 32'h55);
    rdChk("R13 counter read-only", A_CNT, 257);
    rdChk("R13 read 0x00", 8'h00, 0);
    rdChk("R13 read 0x18", 8'h18, 0);
    rdChk("R13 read 0x06", 8'h06, 0);
    wr(8'h18, 32'hFFFF_FFFF);
    rdChk("R13 control untouched", A_CTL, 32'h8000_2000);
    rdChk("R13 alarm untouched", A_ALARM, 0);
    rdChk("R13 wake untouched", A_WAKE, 4);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tCount();
    tRestart();
    tConfig();
    tPrescale();
    tBusy();
    tAlarm();
    tWake();
    tWrap();
    tUnmapped();
    summary();
    $finish;
  end
endmodule